// File: doc/BRIEF.md
# Time-Slot Interchange Group Switch

This block moves bytes between time positions and links. Every clock is one slot period. In each period the block accepts one byte from every incoming link. It stores all of those bytes, as a single word, into every switch-memory bank. The banks are arranged as several parallel switch blocks, each holding several chips. Each stored word is therefore copied into every bank.

For each outgoing link and each outgoing slot, a programmable control memory holds a 16-bit read pointer. The pointer names:
- a switch block,
- a chip,
- a source slot,
- a source link.

The output byte is the byte found at the position the pointer names.

The switch memory is double buffered. Writes fill one half while reads drain the other half, and the halves swap at every frame boundary. As a result, each output carries data from the previous complete frame.

A call-control processor updates pointers through a simple write port. Its writes land in a shadow copy, and that copy becomes active only at the next frame boundary. A connection therefore never changes in the middle of a frame.

Top module: `tsi_group_switch`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_bytes` and `out_slot` are zero. Reset sets every read pointer to 0x0000, which is a valid pointer to link 0, slot 0.
- R2: The byte of incoming link `l` in slot `s` is taken from `in_bytes[l*8 +: 8]`. It is readable by every outgoing slot of the frame that follows. The frame boundary is the clock edge at which `slot_idx` equals `NUM_SLOT-1`.
- R3: A read pointer is decoded as follows: bits [15:13] are the source block, bits [12:11] the chip, bits [10:6] the source slot, and bits [5:0] the source link. For a valid pointer, the output byte equals the input byte of that source link and source slot from the previous frame.
- R4: The result for slot period `j` appears two clocks after `slot_idx` = `j` was presented, and it is accompanied by `out_slot` = `j`.
- R5: A pointer write (`cm_we`, `cm_link`, `cm_slot`, `cm_ptr`) is held in a shadow copy. The shadow copy is copied to the active map at the next boundary edge. A write sampled at the boundary edge itself waits for the boundary after that.
- R6: A pointer whose block is ≥ `NUM_BLK`, chip is ≥ `NUM_CHIP`, link is ≥ `NUM_LINK`, or slot is ≥ `NUM_SLOT` produces the byte 0x00.
- R7: All `NUM_BLK*NUM_CHIP` banks hold identical data. Any valid choice of block and chip yields the same byte for a given slot and link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot-period clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_idx | input | SLT_W | Current slot within the frame, advanced by one each clock |
| in_bytes | input | NUM_LINK*DW | One incoming byte per link; link `l` is at bits `[l*DW +: DW]` |
| cm_we | input | 1 | Pointer write strobe |
| cm_link | input | LIDX_W | Outgoing link whose pointer is written |
| cm_slot | input | SLT_W | Outgoing slot whose pointer is written |
| cm_ptr | input | 16 | New read pointer |
| out_bytes | output | NUM_LINK*DW | One outgoing byte per link |
| out_slot | output | SLT_W | Slot index that `out_bytes` belongs to |

## Verification
The assertions assume the following about the inputs:
- `slot_idx` starts at 0 when reset is released.
- `slot_idx` then steps by one on every clock, wrapping after `NUM_SLOT-1`, so that frame boundaries fall where the half swap expects them.

The stimulus drives a free-running slot counter from reset onward and never skips or repeats a slot. Pointer writes arrive at any slot, including the boundary slot, and at most one arrives per clock. The stimulus also always uses power-of-two link and slot counts, so that the index ports cover exactly the existing entries.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int PTR_W = 16;

  // Read pointer layout: source block, chip, slot, link (MSB to LSB).
  typedef struct packed {
    logic [2:0] blk;
    logic [1:0] chip;
    logic [4:0] slot;
    logic [5:0] link;
  } tsi_ptr_t;
endpackage

// File: rtl/tsi_ctrl_mem.sv
module tsi_ctrl_mem
  import tsi_pkg::*;
#(
  parameter int NUM_LINK = 4,
  parameter int NUM_SLOT = 32,
  parameter int LIDX_W   = 2,
  parameter int SLT_W    = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [LIDX_W-1:0]                wr_link,
  input  logic [SLT_W-1:0]                 wr_slot,
  input  logic [PTR_W-1:0]                 wr_ptr,
  input  logic                             commit,
  input  logic [SLT_W-1:0]                 rd_slot,
  output logic [NUM_LINK-1:0][PTR_W-1:0]   rd_ptr
);
  logic [PTR_W-1:0] shadow [NUM_LINK][NUM_SLOT];
  logic [PTR_W-1:0] active [NUM_LINK][NUM_SLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_LINK; k++) begin
        for (int j = 0; j < NUM_SLOT; j++) begin
          shadow[k][j] <= '0;
          active[k][j] <= '0;
        end
      end
    end else begin
      if (commit) active <= shadow;
      if (wr_en)  shadow[wr_link][wr_slot] <= wr_ptr;
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_LINK; k++) rd_ptr[k] = active[k][rd_slot];
  end
endmodule

// File: rtl/tsi_sm_bank.sv
module tsi_sm_bank #(
  parameter int WORD_W = 32,
  parameter int AW     = 6,
  parameter int NRD    = 4
) (
  input  logic                         clk,
  input  logic [AW-1:0]                wr_addr,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic [NRD-1:0][AW-1:0]       rd_addr,
  output logic [NRD-1:0][WORD_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    mem[wr_addr] <= wr_data;
    for (int r = 0; r < NRD; r++) rd_data[r] <= mem[rd_addr[r]];
  end
endmodule

// File: rtl/tsi_group_switch.sv
module tsi_group_switch
  import tsi_pkg::*;
#(
  parameter int NUM_BLK  = 2,
  parameter int NUM_CHIP = 2,
  parameter int NUM_LINK = 4,
  parameter int NUM_SLOT = 32,
  parameter int DW       = 8,
  localparam int SLT_W   = $clog2(NUM_SLOT),
  localparam int LIDX_W  = (NUM_LINK > 1) ? $clog2(NUM_LINK) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SLT_W-1:0]         slot_idx,
  input  logic [NUM_LINK*DW-1:0]   in_bytes,
  input  logic                     cm_we,
  input  logic [LIDX_W-1:0]        cm_link,
  input  logic [SLT_W-1:0]         cm_slot,
  input  logic [PTR_W-1:0]         cm_ptr,
  output logic [NUM_LINK*DW-1:0]   out_bytes,
  output logic [SLT_W-1:0]         out_slot
);
  localparam int NBANK   = NUM_BLK * NUM_CHIP;
  localparam int BANK_IW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int WORD_W  = NUM_LINK * DW;
  localparam int AW      = SLT_W + 1;

  logic                                wr_half;
  logic                                last_slot;
  logic [NUM_LINK-1:0][PTR_W-1:0]      ptrs;
  logic [NUM_LINK-1:0]                 rd_ok;
  logic [NUM_LINK-1:0][AW-1:0]         rd_addr;
  logic [NUM_LINK-1:0][BANK_IW-1:0]    rd_bank;
  logic [NUM_LINK-1:0][LIDX_W-1:0]     rd_lane;
  logic [NBANK-1:0][NUM_LINK-1:0][WORD_W-1:0] bank_rd;

  logic [NUM_LINK-1:0]                 ok_q;
  logic [NUM_LINK-1:0][BANK_IW-1:0]    bank_q;
  logic [NUM_LINK-1:0][LIDX_W-1:0]     lane_q;
  logic [SLT_W-1:0]                    slot_q;
  logic [NUM_LINK-1:0][DW-1:0]         out_q;

  assign last_slot = (slot_idx == SLT_W'(NUM_SLOT - 1));

  // Frame-level write half; swaps on the last slot edge of each frame.
  always_ff @(posedge clk) begin
    if (rst) wr_half <= 1'b0;
    else if (last_slot) wr_half <= ~wr_half;
  end

  tsi_ctrl_mem #(
    .NUM_LINK(NUM_LINK), .NUM_SLOT(NUM_SLOT), .LIDX_W(LIDX_W), .SLT_W(SLT_W)
  ) u_cm (
    .clk(clk), .rst(rst),
    .wr_en(cm_we), .wr_link(cm_link), .wr_slot(cm_slot), .wr_ptr(cm_ptr),
    .commit(last_slot), .rd_slot(slot_idx), .rd_ptr(ptrs)
  );

  // Pointer decode per outgoing link.
  always_comb begin
    for (int k = 0; k < NUM_LINK; k++) begin
      tsi_ptr_t p;
      p = tsi_ptr_t'(ptrs[k]);
      rd_ok[k]   = (int'(p.blk) < NUM_BLK) && (int'(p.chip) < NUM_CHIP) &&
                   (int'(p.link) < NUM_LINK) && (int'(p.slot) < NUM_SLOT);
      rd_addr[k] = {~wr_half, p.slot[SLT_W-1:0]};
      rd_bank[k] = BANK_IW'(int'(p.blk) * NUM_CHIP + int'(p.chip));
      rd_lane[k] = p.link[LIDX_W-1:0];
    end
  end

  // Replicated switch memory: every block, every chip gets the same word.
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    for (genvar c = 0; c < NUM_CHIP; c++) begin : g_chip
      tsi_sm_bank #(.WORD_W(WORD_W), .AW(AW), .NRD(NUM_LINK)) u_bank (
        .clk(clk),
        .wr_addr({wr_half, slot_idx}),
        .wr_data(in_bytes),
        .rd_addr(rd_addr),
        .rd_data(bank_rd[b*NUM_CHIP + c])
      );
    end
  end

  // Stage 1: align the select information with the bank read data.
  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q   <= '0;
      bank_q <= '0;
      lane_q <= '0;
      slot_q <= '0;
    end else begin
      ok_q   <= rd_ok;
      bank_q <= rd_bank;
      lane_q <= rd_lane;
      slot_q <= slot_idx;
    end
  end

  // Stage 2: bank and byte-lane selection into the output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q    <= '0;
      out_slot <= '0;
    end else begin
      out_slot <= slot_q;
      for (int k = 0; k < NUM_LINK; k++)
        out_q[k] <= ok_q[k] ? bank_rd[bank_q[k]][k][lane_q[k]*DW +: DW] : '0;
    end
  end

  assign out_bytes = out_q;
endmodule

// File: rtl/tsi_group_switch_chk.sv
module tsi_group_switch_chk #(
  parameter int NUM_LINK = 4,
  parameter int NUM_SLOT = 32,
  parameter int DW       = 8,
  localparam int SLT_W   = $clog2(NUM_SLOT)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [SLT_W-1:0]       slot_idx,
  input logic                   wr_half,
  input logic [NUM_LINK-1:0]    rd_ok,
  input logic [NUM_LINK*DW-1:0] out_bytes,
  input logic [SLT_W-1:0]       out_slot
);
  logic [1:0]          cyc;
  logic [SLT_W-1:0]    slot_d1, slot_d2;
  logic                half_d1;
  logic [NUM_LINK-1:0] ok_d1, ok_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc <= '0; slot_d1 <= '0; slot_d2 <= '0; half_d1 <= 1'b0;
      ok_d1 <= '0; ok_d2 <= '0;
    end else begin
      if (cyc != 2'd2) cyc <= cyc + 2'd1;
      slot_d1 <= slot_idx; slot_d2 <= slot_d1;
      half_d1 <= wr_half;
      ok_d1 <= rd_ok; ok_d2 <= ok_d1;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (out_bytes == '0 && out_slot == '0));

  a_r2_half_swap: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0) |->
      (wr_half == ((slot_d1 == SLT_W'(NUM_SLOT - 1)) ? ~half_d1 : half_d1)));

  a_r4_slot_latency: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd2) |-> (out_slot == slot_d2));

  for (genvar k = 0; k < NUM_LINK; k++) begin : g_link
    a_r6_invalid_zero: assert property (@(posedge clk) disable iff (rst)
      (cyc == 2'd2 && !ok_d2[k]) |-> (out_bytes[k*DW +: DW] == '0));
  end
endmodule

bind tsi_group_switch tsi_group_switch_chk #(
  .NUM_LINK(NUM_LINK), .NUM_SLOT(NUM_SLOT), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .slot_idx(slot_idx), .wr_half(wr_half),
  .rd_ok(rd_ok), .out_bytes(out_bytes), .out_slot(out_slot)
);

// File: tb/tb_tsi_group_switch.sv
module tb_tsi_group_switch;
  localparam int PERIOD = 10;
  localparam int NB = 2, NC = 2, NL = 4, NS = 32, DW = 8;
  localparam int FRAMES = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0]     slot_idx = '0;
  logic [NL*DW-1:0] in_bytes = '0;
  logic           cm_we = 1'b0;
  logic [1:0]     cm_link = '0;
  logic [4:0]     cm_slot = '0;
  logic [15:0]    cm_ptr = '0;
  logic [NL*DW-1:0] out_bytes;
  logic [4:0]     out_slot;

  int total = 0, bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  tsi_group_switch #(.NUM_BLK(NB), .NUM_CHIP(NC), .NUM_LINK(NL),
                     .NUM_SLOT(NS), .DW(DW)) dut (
    .clk(clk), .rst(rst), .slot_idx(slot_idx), .in_bytes(in_bytes),
    .cm_we(cm_we), .cm_link(cm_link), .cm_slot(cm_slot), .cm_ptr(cm_ptr),
    .out_bytes(out_bytes), .out_slot(out_slot));

  // Behavioural model state
  int shadow [NL][NS];
  int active [NL][NS];
  int cur    [NS][NL];
  int prev   [NS][NL];
  bit prev_ok = 0;

  // Two-deep expectation pipeline
  int p1_exp [NL], p2_exp [NL];
  bit p1_chk [NL], p2_chk [NL];
  bit p1_inv [NL], p2_inv [NL];
  int p1_slot = 0, p2_slot = 0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int make_ptr(int blk, int chip, int slot, int link);
    return ((blk & 7) << 13) | ((chip & 3) << 11) | ((slot & 31) << 6) | (link & 63);
  endfunction

  // Pointer planned for entry (k, j) in phase A (all valid) or B (mixed).
  function automatic int plan_ptr(bit phase_b, int k, int j);
    if (!phase_b)
      return make_ptr((k + j) % NB, (j / 2) % NC, (j * 7 + k * 3) % NS, (k + 1 + j) % NL);
    case (j % 4)
      0: return make_ptr(2 + (j % 6), 0, j, k);
      1: return make_ptr(1, 2 + (k % 2), j, 1);
      2: return make_ptr(0, 1, 3, 4 + j + k);
      default: return make_ptr(k % NB, 1, 5, 2);
    endcase
  endfunction

  initial begin
    for (int k = 0; k < NL; k++)
      for (int j = 0; j < NS; j++) begin shadow[k][j] = 0; active[k][j] = 0; end
    for (int k = 0; k < NL; k++) begin p1_chk[k] = 0; p2_chk[k] = 0; end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared under reset
    check("R1 out_bytes in reset", int'(out_bytes), 0);
    check("R1 out_slot in reset", int'(out_slot), 0);

    for (int n = 0; n < FRAMES * NS; n++) begin
      int s, fr, pb, ps, pl, pc, ptr;
      bit we;
      int wl, wsl, wp;
      s = n % NS; fr = n / NS;

      // compare result for cycle n-2
      if (n >= 2) begin
        check("R4 out_slot", int'(out_slot), p2_slot);
        for (int k = 0; k < NL; k++)
          if (p2_chk[k])
            check(p2_inv[k] ? "R6 invalid pointer gives zero"
                            : "R2/R3/R5/R7 switched byte",
                  int'(out_bytes[k*DW +: DW]), p2_exp[k]);
      end
      if (n == 2) begin
        // R1: first outputs after reset come from pointer 0x0000 (link 0 slot 0)
        check("R1 first out_slot after reset", int'(out_slot), 0);
      end

      // drive inputs for cycle n
      rst = 1'b0;
      slot_idx = 5'(s);
      for (int l = 0; l < NL; l++)
        in_bytes[l*DW +: DW] = 8'((n * 29 + l * 83 + fr * 7) ^ (l << 5));
      we = 0; wl = 0; wsl = 0; wp = 0;
      if ((fr >= 2 && fr < 6) || (fr >= 8 && fr < 12)) begin
        int idx;
        idx = (fr >= 8) ? n - 8 * NS : n - 2 * NS;
        we = 1; wl = idx % NL; wsl = idx / NL;
        wp = plan_ptr(fr >= 8, wl, wsl);
      end
      cm_we = we; cm_link = 2'(wl); cm_slot = 5'(wsl); cm_ptr = 16'(wp);

      // expectation for cycle n
      p2_exp = p1_exp; p2_chk = p1_chk; p2_inv = p1_inv; p2_slot = p1_slot;
      p1_slot = s;
      for (int k = 0; k < NL; k++) begin
        ptr = active[k][s];
        pb = (ptr >> 13) & 7; pc = (ptr >> 11) & 3;
        ps = (ptr >> 6) & 31; pl = ptr & 63;
        if (pb >= NB || pc >= NC || pl >= NL || ps >= NS) begin
          p1_inv[k] = 1; p1_chk[k] = 1; p1_exp[k] = 0;
        end else begin
          p1_inv[k] = 0; p1_chk[k] = prev_ok;
          p1_exp[k] = prev_ok ? prev[ps][pl] : 0;
        end
      end

      // model update
      for (int l = 0; l < NL; l++) cur[s][l] = int'(in_bytes[l*DW +: DW]);
      if (s == NS - 1) begin
        for (int k = 0; k < NL; k++)
          for (int j = 0; j < NS; j++) active[k][j] = shadow[k][j];
        for (int j = 0; j < NS; j++)
          for (int l = 0; l < NL; l++) prev[j][l] = cur[j][l];
        prev_ok = 1;
      end
      if (we) shadow[wl][wsl] = wp;

      @(negedge clk);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule